// File: doc/BRIEF.md
# GPU Multi-Level Page Table Walker

This block turns a virtual address within one of up to 64 address-space contexts into a physical address. It walks a four-level translation table kept in memory, with 16 KiB pages. A client hands it a context number and a 64-bit virtual address through a valid/ready handshake. The walker then fetches one 64-bit descriptor per level through a simple single-outstanding memory read port. It answers with a single response pulse that carries the physical address, the raw last descriptor, a fault flag and the level the walk ended at.

The table shape is uneven. Each context owns a two-entry root slot at a fixed region base. Below that is an 8-entry level, then two levels of 2048 entries. Root descriptors use their own layout: an address-space tag in the top bits, a next-table base stored pre-shifted by one bit, and a single valid bit. Lower descriptors need both of their two lowest bits set to count as valid. The walk ends at the first invalid descriptor and reports an unmapped fault. Software builds and maintains all tables. The walker only reads them.

Top module: `gpu_table_walker`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while idle, and it stays low from the acceptance edge until the response pulse has been given.
- R2: Only virtual address bits 39:0 take part in the walk. Bits 63:40 have no effect on any output.
- R3: The root entry is read at `REGION_BASE + ctx*16 + va[39]*8`.
- R4: Lower levels take their index from va[38:36], va[35:25] and va[24:14] in that order. Each is read at the current table base plus index*8.
- R5: A root descriptor is valid when bit 0 is 1. Its next-table base is bits 47:1 shifted left by one, so the base may be any 2-byte-aligned address. Bits 63:48 are ignored.
- R6: A descriptor below the root is valid only when bits 1:0 are both 1. Its table or page base is bits 47:14 shifted left by 14. All other bits are ignored.
- R7: At the first invalid descriptor the walk stops with no further reads. It reports `rsp_fault`=1, `rsp_level` = the level of that descriptor (0 to 3), `rsp_pa`=0 and `rsp_desc` = the invalid descriptor.
- R8: A fully valid walk makes exactly four reads. It reports `rsp_fault`=0, `rsp_level`=3, `rsp_desc` = the raw leaf descriptor and `rsp_pa` = leaf bits 47:14 shifted left by 14, ORed with va[13:0].
- R9: At most one read is in flight. `mem_req` stays high with a stable `mem_addr` until `mem_ready`, and no new read starts before `mem_rvalid` has returned the data.
- R10: Every accepted request gives exactly one `rsp_valid` pulse, one cycle long.
- R11: A synchronous active-high `rst` abandons any walk. On the next cycle `req_ready` is 1, `mem_req` is 0 and `rsp_valid` is 0, and a later request is walked correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_ctx | input | CTX_W | Address-space context number |
| req_va | input | 64 | Virtual address |
| mem_req | output | 1 | Descriptor read request |
| mem_ready | input | 1 | Memory takes the read this cycle |
| mem_addr | output | 48 | Byte address of the descriptor |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 64 | Descriptor value |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_pa | output | 48 | Physical address (0 on fault) |
| rsp_desc | output | 64 | Last descriptor read |
| rsp_fault | output | 1 | Unmapped fault |
| rsp_level | output | 2 | Level where the walk ended |

## Verification
The bench sweeps all 64 contexts against every level-1 index and both root slots. It puts junk in the upper address bits, so a walker that failed to mask them would fetch from the wrong tables. Root tables sit at addresses aligned to only 64 bytes, so a root decode that used the 16 KiB field layout would miss its table and fault.

Invalid descriptors are placed at every level. One has only bit 0 set and another has only bit 1 set, which catches a walker that tests a single bit or keeps reading past a fault. For each walk the bench counts memory reads and checks the single-pulse response. Odd contexts hold `mem_ready` low on alternate cycles, which shows up any address that drifts while the read is held. A reset in the middle of a walk, followed by a clean walk, checks that no stale read or response survives.

// File: rtl/gptw_pkg.sv
package gptw_pkg;

    localparam int PA_W            = 48;
    localparam int DESC_W          = 64;
    localparam int VA_IN_W         = 64;
    localparam int PAGE_SHIFT      = 14;
    localparam int NUM_LVL         = 4;
    localparam int LVL_W           = $clog2(NUM_LVL);
    localparam int DESC_BYTES_LOG2 = 3;

    // bit position of each level's index field in the virtual address
    function automatic int lvl_shift(input int lvl);
        case (lvl)
            0:       return 39;
            1:       return 36;
            2:       return 25;
            default: return 14;
        endcase
    endfunction

    // index width of each level (entries = 2**width)
    function automatic int lvl_bits(input int lvl);
        case (lvl)
            0:       return 1;
            1:       return 3;
            default: return 11;
        endcase
    endfunction

    localparam int VA_IMPL_W = lvl_shift(0) + lvl_bits(0);

    typedef logic [PA_W-1:0] paddr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } walk_state_e;

    typedef struct packed {
        logic [LVL_W-1:0]     level;
        paddr_t               base;
        logic [VA_IMPL_W-1:0] va;
    } walk_ctx_t;

    typedef struct packed {
        logic   valid;
        paddr_t next_base;
    } desc_info_t;

endpackage

// File: rtl/gptw_index.sv
module gptw_index
    import gptw_pkg::*;
#(
    parameter int     CTX_W       = 6,
    parameter paddr_t REGION_BASE = 48'h0000_0010_0000
) (
    input  logic [LVL_W-1:0]                level,
    input  logic [CTX_W-1:0]                ctx,
    input  logic [VA_IMPL_W-1:PAGE_SHIFT]   va_idx,
    input  paddr_t                          table_base,
    output paddr_t                          entry_addr
);
    // each context owns one root slot of 2**lvl_bits(0) descriptors
    localparam int ROOT_SLOT_LOG2 = lvl_bits(0) + DESC_BYTES_LOG2;

    paddr_t idx_off [NUM_LVL];
    paddr_t root_base;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        localparam int SH = lvl_shift(l);
        localparam int BW = lvl_bits(l);
        assign idx_off[l] = paddr_t'(va_idx[SH +: BW]) << DESC_BYTES_LOG2;
    end

    assign root_base = REGION_BASE + (paddr_t'(ctx) << ROOT_SLOT_LOG2);

    always_comb begin
        entry_addr = ((level == '0) ? root_base : table_base) + idx_off[level];
    end

endmodule

// File: rtl/gptw_desc_decode.sv
module gptw_desc_decode
    import gptw_pkg::*;
(
    input  logic [LVL_W-1:0] level,
    input  logic [PA_W-1:0]  desc,
    output desc_info_t       info
);
    always_comb begin
        if (level == '0) begin
            // root layout: tag above PA_W, base stored pre-shifted by one
            info.valid     = desc[0];
            info.next_base = {desc[PA_W-1:1], 1'b0};
        end else begin
            info.valid     = desc[1] & desc[0];
            info.next_base = {desc[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
        end
    end

endmodule

// File: rtl/gpu_table_walker.sv
module gpu_table_walker
    import gptw_pkg::*;
#(
    parameter int     CTX_W       = 6,
    parameter paddr_t REGION_BASE = 48'h0000_0010_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [CTX_W-1:0]     req_ctx,
    input  logic [VA_IN_W-1:0]   req_va,
    output logic                 mem_req,
    input  logic                 mem_ready,
    output logic [PA_W-1:0]      mem_addr,
    input  logic                 mem_rvalid,
    input  logic [DESC_W-1:0]    mem_rdata,
    output logic                 rsp_valid,
    output logic [PA_W-1:0]      rsp_pa,
    output logic [DESC_W-1:0]    rsp_desc,
    output logic                 rsp_fault,
    output logic [LVL_W-1:0]     rsp_level
);
    localparam int NUM_CTX  = 1 << CTX_W;
    localparam logic [LVL_W-1:0] LEAF_LVL = LVL_W'(NUM_LVL - 1);

    walk_state_e          state;
    walk_ctx_t            cur;
    logic [CTX_W-1:0]     cur_ctx;
    paddr_t               entry_addr;
    desc_info_t           info;
    logic                 va_high_unused;

    assign va_high_unused = ^req_va[VA_IN_W-1:VA_IMPL_W];

    gptw_index #(
        .CTX_W       (CTX_W),
        .REGION_BASE (REGION_BASE)
    ) u_index (
        .level      (cur.level),
        .ctx        (cur_ctx),
        .va_idx     (cur.va[VA_IMPL_W-1:PAGE_SHIFT]),
        .table_base (cur.base),
        .entry_addr (entry_addr)
    );

    gptw_desc_decode u_decode (
        .level (cur.level),
        .desc  (mem_rdata[PA_W-1:0]),
        .info  (info)
    );

    assign req_ready = (state == ST_IDLE);
    assign mem_req   = (state == ST_ISSUE);
    assign mem_addr  = entry_addr;
    assign rsp_valid = (state == ST_RESP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur       <= '0;
            cur_ctx   <= '0;
            rsp_pa    <= '0;
            rsp_desc  <= '0;
            rsp_fault <= 1'b0;
            rsp_level <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur.va    <= req_va[VA_IMPL_W-1:0];
                        cur.level <= '0;
                        cur.base  <= '0;
                        cur_ctx   <= req_ctx;
                        state     <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (mem_ready) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        if (!info.valid) begin
                            rsp_desc  <= mem_rdata;
                            rsp_level <= cur.level;
                            rsp_fault <= 1'b1;
                            rsp_pa    <= '0;
                            state     <= ST_RESP;
                        end else if (cur.level == LEAF_LVL) begin
                            rsp_desc  <= mem_rdata;
                            rsp_level <= cur.level;
                            rsp_fault <= 1'b0;
                            rsp_pa    <= info.next_base | paddr_t'(cur.va[PAGE_SHIFT-1:0]);
                            state     <= ST_RESP;
                        end else begin
                            cur.level <= cur.level + 1'b1;
                            cur.base  <= info.next_base;
                            state     <= ST_ISSUE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    initial begin
        if (NUM_CTX < 1) $error("context count must be positive");
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);                          // R1
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr));         // R9
    AST_NO_REQ_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ready |=> !mem_req);                              // R9
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);                                       // R10
    AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault |-> rsp_pa == '0);                        // R7
    AST_LEAF_LEVEL: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_fault |-> rsp_level == LEAF_LVL);              // R8

endmodule

// File: tb/gpu_table_walker_tb.sv
module gpu_table_walker_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] RBASE = 48'h0000_0010_0000;
    localparam logic [47:0] L1B   = 48'h0100_0000_0000;
    localparam logic [47:0] L2B   = 48'h0200_0000_0000;
    localparam logic [47:0] L3B   = 48'h0400_0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [5:0]  req_ctx = '0;
    logic [63:0] req_va = '0;
    logic        mem_req;
    logic        mem_ready;
    logic [47:0] mem_addr;
    logic        mem_rvalid;
    logic [63:0] mem_rdata;
    logic        rsp_valid;
    logic [47:0] rsp_pa;
    logic [63:0] rsp_desc;
    logic        rsp_fault;
    logic [1:0]  rsp_level;

    int n_chk = 0;
    int n_bad = 0;
    int reads = 0;
    int r9_bad = 0;
    logic stall = 1'b0;
    logic prev_hold = 1'b0;
    logic [47:0] prev_addr = '0;
    int fault_seen [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpu_table_walker #(.CTX_W(6), .REGION_BASE(RBASE)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_ctx(req_ctx), .req_va(req_va), .mem_req(mem_req), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_desc(rsp_desc),
        .rsp_fault(rsp_fault), .rsp_level(rsp_level)
    );

    // synthetic table contents, defined by table identity and index
    function automatic logic [63:0] d_l0(longint ctx, longint i0);
        logic [47:0] t = L1B + 48'((ctx*2 + i0) * 64);
        if (ctx % 5 == 3 && i0 == 1) return {16'h0, t};
        return {16'(ctx), t[47:1], 1'b1};
    endfunction

    function automatic logic [63:0] d_l1(longint id1, longint i1);
        logic [47:0] t = L2B + (48'(id1*8 + i1) << 14);
        logic [13:0] lo = (i1 == 7 && id1 % 2 == 1) ? 14'h402 : 14'h403;
        return {16'hBEEF, t[47:14], lo};
    endfunction

    function automatic logic [63:0] d_l2(longint id2, longint i2);
        logic [47:0] t = L3B + (48'(id2*2048 + i2) << 14);
        logic [13:0] lo = (i2 % 97 == 5) ? 14'h401 : 14'h403;
        return {16'hC0DE, t[47:14], lo};
    endfunction

    function automatic logic [63:0] d_l3(longint id3, longint i3);
        logic [33:0] fr = 34'((id3*2048 + i3) * 7 + 3);
        logic [13:0] lo = (i3 % 89 == 11) ? 14'h6C2 : 14'h6C3;
        return {16'hA5C3, fr, lo};
    endfunction

    function automatic logic [63:0] mem_word(logic [47:0] a);
        logic [47:0] off;
        if (a[2:0] != 3'b0) return 64'h0;
        if (a >= RBASE && a < RBASE + 48'd1024) begin
            off = a - RBASE;
            return d_l0(longint'(off >> 4), longint'(off[3]));
        end
        if (a[47:40] == 8'h01) return d_l1(longint'(a[39:6]), longint'(a[5:3]));
        if (a[47:40] == 8'h02) return d_l2(longint'(a[39:14]), longint'(a[13:3]));
        if (a[47:42] == 6'b000001) return d_l3(longint'(a[41:14]), longint'(a[13:3]));
        return 64'h0;
    endfunction

    // memory model: answers one cycle after the grant; checks R9 at the port
    always @(posedge clk) begin
        if (rst) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            mem_ready  <= 1'b1;
            prev_hold  <= 1'b0;
        end else begin
            if (mem_req && mem_rvalid) r9_bad <= r9_bad + 1;
            if (prev_hold && (!mem_req || mem_addr != prev_addr)) r9_bad <= r9_bad + 1;
            prev_hold  <= mem_req && !mem_ready;
            prev_addr  <= mem_addr;
            mem_rvalid <= mem_req && mem_ready;
            if (mem_req && mem_ready) begin
                mem_rdata <= mem_word(mem_addr);
                reads     <= reads + 1;
            end
            mem_ready <= stall ? ~mem_ready : 1'b1;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_walk(logic [5:0] ctx, logic [63:0] va);
        logic [63:0] d0, d1, d2, d3, e_desc;
        logic [47:0] e_pa;
        logic        e_fault;
        logic [1:0]  e_lvl;
        int e_reads, base_reads, busy_bad, cyc;
        longint i0, i1, i2, i3, id1, id2, id3;
        logic got;
        i0 = longint'(va[39]);    i1 = longint'(va[38:36]);
        i2 = longint'(va[35:25]); i3 = longint'(va[24:14]);
        id1 = longint'(ctx)*2 + i0; id2 = id1*8 + i1; id3 = id2*2048 + i2;
        d0 = d_l0(longint'(ctx), i0); d1 = d_l1(id1, i1);
        d2 = d_l2(id2, i2);           d3 = d_l3(id3, i3);
        e_pa = '0; e_fault = 1'b1;
        if (!d0[0])             begin e_lvl = 0; e_desc = d0; e_reads = 1; end
        else if (d1[1:0] != 3)  begin e_lvl = 1; e_desc = d1; e_reads = 2; end
        else if (d2[1:0] != 3)  begin e_lvl = 2; e_desc = d2; e_reads = 3; end
        else if (d3[1:0] != 3)  begin e_lvl = 3; e_desc = d3; e_reads = 4; end
        else begin
            e_lvl = 3; e_desc = d3; e_reads = 4; e_fault = 1'b0;
            e_pa = {d3[47:14], va[13:0]};
        end

        @(negedge clk);
        chk("R1 ready when idle", 64'(req_ready), 64'd1);
        base_reads = reads;
        req_valid = 1'b1; req_ctx = ctx; req_va = va;
        @(negedge clk);
        req_valid = 1'b0; req_va = ~va;
        busy_bad = 0; got = 1'b0;
        for (cyc = 0; cyc < 300; cyc++) begin
            if (rsp_valid) begin got = 1'b1; break; end
            if (req_ready) busy_bad++;
            @(negedge clk);
        end
        chk("R10 response arrives", 64'(got), 64'd1);
        chk("R1 busy during walk", 64'(busy_bad), 64'd0);
        if (got) begin
            chk("R7 R8 fault flag", 64'(rsp_fault), 64'(e_fault));
            chk("R7 R8 level", 64'(rsp_level), 64'(e_lvl));
            chk("R2 R3 R4 R5 R6 R8 pa", 64'(rsp_pa), 64'(e_pa));
            chk("R7 R8 desc", rsp_desc, e_desc);
            chk("R7 R8 read count", 64'(reads - base_reads), 64'(e_reads));
            if (rsp_fault) fault_seen[rsp_level]++;
            @(negedge clk);
            chk("R10 single pulse", 64'(rsp_valid), 64'd0);
        end
    endtask

    function automatic logic [63:0] mk_va(int ctx, int i0, int i1, int i2, int i3, int off);
        return {24'(24'hF00D00 ^ ctx), 1'(i0), 3'(i1), 11'(i2), 11'(i3), 14'(off)};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        for (int l = 0; l < 4; l++) fault_seen[l] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset ready", 64'(req_ready), 64'd1);
        chk("R11 reset no read", 64'(mem_req), 64'd0);
        chk("R11 reset no response", 64'(rsp_valid), 64'd0);

        // sweep: all contexts, both root slots, all level-1 indices
        for (int c = 0; c < 64; c++) begin
            stall = c[0];
            for (int a = 0; a < 2; a++) begin
                for (int b = 0; b < 8; b++) begin
                    int x2, x3;
                    x2 = (c % 7 == 0 && b == 4) ? 5 : (c*37 + b*5 + a*3) % 2048;
                    x3 = (b == 2) ? 11 : (c*53 + b*29 + a*17 + 100) % 2048;
                    run_walk(6'(c), mk_va(c, a, b, x2, x3, (c*131 + b*977 + a) & 16383));
                end
            end
        end
        stall = 1'b0;

        // index boundaries and upper-bit masking (R2, R4)
        run_walk(6'd63, {24'hFFFFFF, 1'b0, 3'd6, 11'd2047, 11'd2047, 14'h3FFF});
        run_walk(6'd0,  {24'h000000, 1'b0, 3'd0, 11'd0,    11'd0,    14'h0000});
        run_walk(6'd0,  {24'hABCDEF, 1'b0, 3'd0, 11'd0,    11'd0,    14'h0000});

        chk("R7 root faults seen",  64'(fault_seen[0] > 0), 64'd1);
        chk("R7 lvl1 faults seen",  64'(fault_seen[1] > 0), 64'd1);
        chk("R7 lvl2 faults seen",  64'(fault_seen[2] > 0), 64'd1);
        chk("R7 lvl3 faults seen",  64'(fault_seen[3] > 0), 64'd1);
        chk("R9 single outstanding and held address", 64'(r9_bad), 64'd0);

        // reset during a walk (R11)
        @(negedge clk);
        req_valid = 1'b1; req_ctx = 6'd9; req_va = mk_va(9, 0, 1, 40, 50, 7);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11 mid-walk ready", 64'(req_ready), 64'd1);
        chk("R11 mid-walk no read", 64'(mem_req), 64'd0);
        chk("R11 mid-walk no response", 64'(rsp_valid), 64'd0);
        run_walk(6'd9, mk_va(9, 0, 1, 40, 50, 7));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule